// File: doc/BRIEF.md
# Instruction prefix operand-size resolver

This block is a byte-serial front-end stage for a variable-length instruction decoder. It accepts one instruction byte per cycle over a valid/ready handshake. With each byte it also takes two attribute bits of the current code segment: a long-mode flag and a default-size flag. Prefix bytes are absorbed into internal state. When the opcode byte arrives, the block emits one registered result: the effective operand size, the effective address size, the four extension bits of a REX prefix, and the opcode byte itself.

Outside long mode, the default-size flag picks 16-bit or 32-bit for both sizes. Each size-override prefix flips its own size to the other width. In long mode, operands default to 32-bit and addresses to 64-bit. REX.W widens the operand to 64-bit. An operand-size override narrows the operand to 16-bit, and an address-size override narrows the address to 32-bit. The other legacy prefixes pass through without effect. Two conditions raise an error: the reserved segment combination, and a prefix run that is too long.

Top module: `opsz_resolver`

## Requirements
- R1: Outside long mode with no size prefix, both sizes are 16-bit when the default flag is 0 and 32-bit when it is 1. Size codes on the outputs are 0=16, 1=32, 2=64 and 3=no decision.
- R2: Outside long mode, 0x66 flips the operand size and 0x67 flips the address size to the width not chosen by the default flag. Several copies of either prefix act like one.
- R3: In long mode (default flag 0), the operand size is 32-bit without REX.W or 0x66. The address size is 64-bit, or 32-bit when 0x67 was seen.
- R4: In long mode, 0x66 without REX.W gives a 16-bit operand. REX.W=1 gives 64-bit whether or not 0x66 is present.
- R5: A byte 0x40..0x4F is a REX prefix only in long mode, and it counts only when the opcode follows it directly. A legacy prefix after it discards it. out_rex_o carries {W,R,X,B} = REX byte bits [3:0], and is 0 without a valid REX. Outside long mode such a byte is emitted as the opcode.
- R6: The bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0xF0, 0xF2 and 0xF3 are consumed and change no size. Any byte that is neither a prefix nor a REX is emitted unchanged on out_opcode_o.
- R7: With long mode and default flag both 1, the result carries err_reserved_o=1 and both size codes are 3.
- R8: A result appears on the cycle after its opcode is accepted. It stays valid and unchanged, with in_ready_o low, until out_ready_i is seen high. Prefix state is cleared once each opcode has been taken.
- R9: 14 consecutive prefix bytes are allowed. The 15th raises err_overlen_o for exactly one cycle after it is accepted. That byte is dropped and all prefix state is cleared.
- R10: After reset, out_valid_o and both error outputs are low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block can accept a byte |
| in_byte_i | input | 8 | Instruction byte |
| seg_long_i | input | 1 | Code segment is in long mode |
| seg_dflt_i | input | 1 | Code segment default-size flag |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| out_opsz_o | output | 2 | Effective operand size code |
| out_adsz_o | output | 2 | Effective address size code |
| out_rex_o | output | 4 | REX bits {W,R,X,B} |
| out_opcode_o | output | 8 | Opcode byte |
| err_reserved_o | output | 1 | Reserved segment combination |
| err_overlen_o | output | 1 | One-cycle pulse on prefix-run overflow |

## Verification
The bench targets the cases where sizing logic usually goes wrong:
- REX.W paired with 0x66. A design with the wrong priority reports 16-bit instead of 64-bit.
- A REX byte followed by another legacy prefix. A design that keeps the REX leaks stale W/R/X/B bits into the result.
- A 0x4x byte outside long mode. A design that treats it as a prefix swallows the opcode.
- A run of exactly 14 prefixes, then one of 15. An off-by-one counter either flags the legal run or misses the bad one. The bench also checks that state is cleared after the overflow, so an override that survives shows up as the wrong size on the next opcode.
- A result held with out_ready_i low. This catches outputs that move while stalled.

// File: rtl/opsz_pkg.sv
package opsz_pkg;
  typedef enum logic [1:0] {SZ16 = 2'd0, SZ32 = 2'd1, SZ64 = 2'd2, SZNONE = 2'd3} size_e;
  typedef enum logic [1:0] {BK_OPCODE = 2'd0, BK_LEGACY = 2'd1, BK_REX = 2'd2} kind_e;

  function automatic logic is_legacy(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/opsz_byte_class.sv
module opsz_byte_class
  import opsz_pkg::*;
(
  input  logic [7:0] byte_i,
  input  logic       long_i,
  output kind_e      kind_o,
  output logic       is_opsz_o,
  output logic       is_adsz_o
);
  always_comb begin
    if (is_legacy(byte_i))                   kind_o = BK_LEGACY;
    else if (long_i && byte_i[7:4] == 4'h4)  kind_o = BK_REX;
    else                                     kind_o = BK_OPCODE;
  end
  assign is_opsz_o = (byte_i == 8'h66);
  assign is_adsz_o = (byte_i == 8'h67);
endmodule

// File: rtl/opsz_prefix_track.sv
module opsz_prefix_track
  import opsz_pkg::*;
#(
  parameter int MAX_PREFIX = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  kind_e      kind_i,
  input  logic       is_opsz_i,
  input  logic       is_adsz_i,
  input  logic [3:0] rex_bits_i,
  output logic       p66_o,
  output logic       p67_o,
  output logic       rex_v_o,
  output logic [3:0] rex_o,
  output logic       overlen_o
);
  localparam int CW = $clog2(MAX_PREFIX + 1);

  logic [CW-1:0] cnt_q;
  logic          p66_q, p67_q, rex_v_q, ovl_q;
  logic [3:0]    rex_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      p66_q   <= 1'b0;
      p67_q   <= 1'b0;
      rex_v_q <= 1'b0;
      rex_q   <= '0;
      ovl_q   <= 1'b0;
    end else begin
      ovl_q <= 1'b0;
      if (acc_i) begin
        if (kind_i == BK_OPCODE || cnt_q == CW'(MAX_PREFIX)) begin
          // opcode ends the run; overflow drops the byte and resyncs
          cnt_q   <= '0;
          p66_q   <= 1'b0;
          p67_q   <= 1'b0;
          rex_v_q <= 1'b0;
          rex_q   <= '0;
          ovl_q   <= (kind_i != BK_OPCODE);
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (kind_i == BK_LEGACY) begin
            p66_q   <= p66_q | is_opsz_i;
            p67_q   <= p67_q | is_adsz_i;
            rex_v_q <= 1'b0;
            rex_q   <= '0;
          end else begin
            rex_v_q <= 1'b1;
            rex_q   <= rex_bits_i;
          end
        end
      end
    end
  end

  assign p66_o     = p66_q;
  assign p67_o     = p67_q;
  assign rex_v_o   = rex_v_q;
  assign rex_o     = rex_q;
  assign overlen_o = ovl_q;
endmodule

// File: rtl/opsz_size_calc.sv
module opsz_size_calc
  import opsz_pkg::*;
(
  input  logic  long_i,
  input  logic  dflt_i,
  input  logic  p66_i,
  input  logic  p67_i,
  input  logic  rex_w_i,
  output size_e opsz_o,
  output size_e adsz_o,
  output logic  reserved_o
);
  size_e base, alt;

  always_comb begin
    base       = dflt_i ? SZ32 : SZ16;
    alt        = dflt_i ? SZ16 : SZ32;
    reserved_o = long_i && dflt_i;
    if (reserved_o) begin
      opsz_o = SZNONE;
      adsz_o = SZNONE;
    end else if (long_i) begin
      opsz_o = rex_w_i ? SZ64 : (p66_i ? SZ16 : SZ32);
      adsz_o = p67_i ? SZ32 : SZ64;
    end else begin
      opsz_o = p66_i ? alt : base;
      adsz_o = p67_i ? alt : base;
    end
  end
endmodule

// File: rtl/opsz_resolver.sv
module opsz_resolver
  import opsz_pkg::*;
#(
  parameter int MAX_PREFIX = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  input  logic [7:0] in_byte_i,
  input  logic       seg_long_i,
  input  logic       seg_dflt_i,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic [1:0] out_opsz_o,
  output logic [1:0] out_adsz_o,
  output logic [3:0] out_rex_o,
  output logic [7:0] out_opcode_o,
  output logic       err_reserved_o,
  output logic       err_overlen_o
);
  kind_e      kind;
  logic       is_opsz, is_adsz, acc, take_op;
  logic       p66, p67, rex_v, reserved;
  logic [3:0] rex;
  size_e      opsz, adsz;

  logic       vld_q, rsv_q;
  logic [1:0] opsz_q, adsz_q;
  logic [3:0] rex_q;
  logic [7:0] opc_q;

  assign in_ready_o = !vld_q || out_ready_i;
  assign acc        = in_valid_i && in_ready_o;
  assign take_op    = acc && (kind == BK_OPCODE);

  opsz_byte_class u_class (
    .byte_i    (in_byte_i),
    .long_i    (seg_long_i),
    .kind_o    (kind),
    .is_opsz_o (is_opsz),
    .is_adsz_o (is_adsz)
  );

  opsz_prefix_track #(.MAX_PREFIX(MAX_PREFIX)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .kind_i     (kind),
    .is_opsz_i  (is_opsz),
    .is_adsz_i  (is_adsz),
    .rex_bits_i (in_byte_i[3:0]),
    .p66_o      (p66),
    .p67_o      (p67),
    .rex_v_o    (rex_v),
    .rex_o      (rex),
    .overlen_o  (err_overlen_o)
  );

  opsz_size_calc u_calc (
    .long_i     (seg_long_i),
    .dflt_i     (seg_dflt_i),
    .p66_i      (p66),
    .p67_i      (p67),
    .rex_w_i    (rex_v && rex[3]),
    .opsz_o     (opsz),
    .adsz_o     (adsz),
    .reserved_o (reserved)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      rsv_q  <= 1'b0;
      opsz_q <= '0;
      adsz_q <= '0;
      rex_q  <= '0;
      opc_q  <= '0;
    end else if (take_op) begin
      vld_q  <= 1'b1;
      rsv_q  <= reserved;
      opsz_q <= opsz;
      adsz_q <= adsz;
      rex_q  <= rex_v ? rex : 4'h0;
      opc_q  <= in_byte_i;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
      rsv_q <= 1'b0;
    end
  end

  assign out_valid_o    = vld_q;
  assign err_reserved_o = rsv_q;
  assign out_opsz_o     = opsz_q;
  assign out_adsz_o     = adsz_q;
  assign out_rex_o      = rex_q;
  assign out_opcode_o   = opc_q;
endmodule

// File: rtl/opsz_resolver_chk.sv
module opsz_resolver_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_ready_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [1:0] out_opsz_o,
  input logic [1:0] out_adsz_o,
  input logic [3:0] out_rex_o,
  input logic [7:0] out_opcode_o,
  input logic       err_reserved_o,
  input logic       err_overlen_o
);
  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_opsz_o) && $stable(out_adsz_o)
      && $stable(out_rex_o) && $stable(out_opcode_o) && $stable(err_reserved_o));

  // R4
  wide_needs_rexw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_opsz_o == 2'd2 |-> out_rex_o[3]);

  // R7
  reserved_nosize_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && err_reserved_o |-> out_opsz_o == 2'd3 && out_adsz_o == 2'd3);

  // R7
  sized_when_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !err_reserved_o |-> out_opsz_o != 2'd3 && out_adsz_o != 2'd3);

  // R9
  overlen_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_overlen_o |=> !err_overlen_o);

  // R9
  overlen_no_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_overlen_o |-> !$rose(out_valid_o));

  // R8
  stall_blocks_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
endmodule

bind opsz_resolver opsz_resolver_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .in_ready_o     (in_ready_o),
  .out_valid_o    (out_valid_o),
  .out_ready_i    (out_ready_i),
  .out_opsz_o     (out_opsz_o),
  .out_adsz_o     (out_adsz_o),
  .out_rex_o      (out_rex_o),
  .out_opcode_o   (out_opcode_o),
  .err_reserved_o (err_reserved_o),
  .err_overlen_o  (err_overlen_o)
);

// File: tb/opsz_resolver_tb.sv
`timescale 1ns/1ps
module opsz_resolver_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       seg_long = 1'b0, seg_dflt = 1'b0;
  logic       in_ready, out_valid, err_rsv, err_ovl;
  logic [1:0] opsz, adsz;
  logic [3:0] rex;
  logic [7:0] opc;

  int n_chk = 0, n_fail = 0;

  // model state
  bit       m_p66, m_p67, m_rexv;
  bit [3:0] m_rex;
  int       m_cnt;

  always #4 clk = ~clk;

  opsz_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_byte_i(in_byte), .seg_long_i(seg_long), .seg_dflt_i(seg_dflt),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_opsz_o(opsz),
    .out_adsz_o(adsz), .out_rex_o(rex), .out_opcode_o(opc),
    .err_reserved_o(err_rsv), .err_overlen_o(err_ovl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit is_leg(input logic [7:0] b);
    return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
  endfunction

  function automatic logic [1:0] exp_op(input bit l, input bit d, input bit p66, input bit w);
    if (l && d) return 2'd3;
    if (l) return w ? 2'd2 : (p66 ? 2'd0 : 2'd1);
    return (p66 ^ d) ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [1:0] exp_ad(input bit l, input bit d, input bit p67);
    if (l && d) return 2'd3;
    if (l) return p67 ? 2'd1 : 2'd2;
    return (p67 ^ d) ? 2'd1 : 2'd0;
  endfunction

  task automatic model_clear();
    m_p66 = 0; m_p67 = 0; m_rexv = 0; m_rex = 0; m_cnt = 0;
  endtask

  task automatic set_mode(input bit l, input bit d);
    @(negedge clk);
    seg_long = l; seg_dflt = d;
  endtask

  task automatic put(input logic [7:0] b);
    bit emit, ovl, w, l, d, p66, p67;
    logic [3:0] xr;
    logic [1:0] eo, ea;
    string to, ta;
    emit = 0; ovl = 0;
    l = seg_long; d = seg_dflt;
    @(negedge clk);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    p66 = m_p66; p67 = m_p67; w = m_rexv && m_rex[3];
    xr = m_rexv ? m_rex : 4'h0;
    if (is_leg(b) || (l && b[7:4] == 4'h4)) begin
      if (m_cnt == 14) begin
        ovl = 1; model_clear();
      end else begin
        m_cnt++;
        if (is_leg(b)) begin
          if (b == 8'h66) m_p66 = 1;
          if (b == 8'h67) m_p67 = 1;
          m_rexv = 0; m_rex = 0;
        end else begin
          m_rexv = 1; m_rex = b[3:0];
        end
      end
    end else begin
      emit = 1; model_clear();
    end
    chk(err_ovl == ovl, "R9", "err_overlen", err_ovl, ovl);
    if (emit) begin
      eo = exp_op(l, d, p66, w);
      ea = exp_ad(l, d, p67);
      to = (l && d) ? "R7" : l ? (w ? "R4" : (p66 ? "R4" : "R3")) : (p66 ? "R2" : "R1");
      ta = (l && d) ? "R7" : l ? "R3" : (p67 ? "R2" : "R1");
      chk(out_valid == 1'b1, "R8", "out_valid", out_valid, 1);
      chk(opsz == eo, to, "opsz", opsz, eo);
      chk(adsz == ea, ta, "adsz", adsz, ea);
      chk(rex == xr, "R5", "rex", rex, xr);
      chk(opc == b, "R6", "opcode", opc, b);
      chk(err_rsv == (l && d), "R7", "err_reserved", err_rsv, (l && d));
      @(negedge clk);
      chk(out_valid && opsz == eo && adsz == ea && opc == b, "R8", "held result", {opsz, adsz, opc}, {eo, ea, b});
      chk(in_ready == 1'b0, "R8", "in_ready while held", in_ready, 0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      chk(out_valid == 1'b0, "R8", "drained", out_valid, 0);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    model_clear();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10
    chk(!out_valid && !err_rsv && !err_ovl && in_ready, "R10", "reset state",
        {out_valid, err_rsv, err_ovl, in_ready}, 4'b0001);

    // R1 defaults
    set_mode(0, 0); put(8'h90);
    set_mode(0, 1); put(8'h90);
    // R2 repeated toggles
    put(8'h66); put(8'h66); put(8'h67); put(8'h67); put(8'h90);
    set_mode(0, 0); put(8'h66); put(8'h8B);
    // R3 long defaults and address override
    set_mode(1, 0); put(8'h90);
    put(8'h67); put(8'h8B);
    // R4 REX.W precedence
    put(8'h66); put(8'h48); put(8'h89);
    put(8'h66); put(8'h40); put(8'h89);
    // R5 REX discarded by later prefix, REX R/X/B carried
    put(8'h4C); put(8'h66); put(8'h01);
    put(8'h47); put(8'h01);
    set_mode(0, 1); put(8'h45);
    // R6 other legacy prefixes
    set_mode(0, 0);
    put(8'h26); put(8'hF0); put(8'hF3); put(8'h2E); put(8'h3E);
    put(8'h36); put(8'h64); put(8'h65); put(8'hF2); put(8'h90);
    // R7 reserved combination
    set_mode(1, 1); put(8'h48); put(8'h90);
    // R9 boundary: 14 ok, 15 overflows and resyncs
    set_mode(0, 1);
    for (int i = 0; i < 14; i++) put(8'h66);
    put(8'h90);
    for (int i = 0; i < 15; i++) put(8'h66);
    put(8'h90);

    // random instructions
    for (int k = 0; k < 400; k++) begin
      int np, r;
      logic [7:0] b;
      r = $urandom % 8;
      set_mode(r >= 4, (r == 2) || (r == 3) || (r == 7));
      np = $urandom % 6;
      for (int j = 0; j < np; j++) begin
        case ($urandom % 8)
          0: b = 8'h66;
          1: b = 8'h67;
          2: b = 8'h26;
          3: b = 8'hF0;
          4: b = 8'hF3;
          5: b = 8'h64;
          default: b = 8'h40 | 8'($urandom % 16);
        endcase
        put(b);
      end
      do b = 8'($urandom);
      while (is_leg(b) || (seg_long && b[7:4] == 4'h4));
      put(b);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule